// File: doc/BRIEF.md
# Tank Fault Supervisor

This block sits beside the sequence controller of a heated evaporation tank and watches the same level switches, temperature switch and actuator commands to spot faults. It uses two detection methods. The first is a consistency check on sensor pairs, which reports a level reading that cannot occur physically. The second is a set of independent watchdog timers. Each timer runs only while its own process condition holds and reports a fault when that condition lasts longer than a parameterised number of tick pulses.

Each detected fault sets its own flag. The flag holds until a clear pulse arrives and the cause has gone. A registered shutdown output combines all flags so that the sequence controller can stop every actuator. The tick input is a slow time base, for example one pulse per second. The four time limits are parameters counted in ticks. Each limit should be set above the normal duration of its action, but low enough that a real fault is caught before much damage is done.

Top module: `tank_fault_supervisor`

## Requirements
- R1: After reset, `fault_o` is all zero and `shutdown_o` is 0.
- R2: If `lvl_full_i` is 1 while `lvl_half_i` is 0 at a rising clock edge, then `fault_o[0]` is 1 after that edge.
- R3: The fill watchdog counts tick pulses while `fill_open_i` is 1. The tick that brings its count to FILL_LIMIT sets `fault_o[1]`, one clock after that tick's edge; FILL_LIMIT-1 ticks do not set it.
- R4: The drain watchdog behaves in the same way for `drain_open_i` and DRAIN_LIMIT, and sets `fault_o[2]`.
- R5: The cold watchdog is armed only while `heat_on_i` is 1 and `temp_hot_i` is 0. Reaching COLD_LIMIT ticks sets `fault_o[3]`. While the heater is off, cold readings are not counted.
- R6: The hot watchdog is armed while `temp_hot_i` is 1. Reaching HOT_LIMIT ticks sets `fault_o[4]`.
- R7: A watchdog's count returns to zero in any cycle in which its arming condition is false. Clock cycles without a tick pulse do not advance the count.
- R8: A set fault flag stays set while `clear_i` is 0, even after its cause has gone.
- R9: A one-cycle `clear_i` pulse clears each flag whose cause is absent in that cycle. A flag whose cause is still present, including an expired watchdog that is still armed, stays set.
- R10: `shutdown_o` is a register equal to the OR of `fault_o` in the previous cycle. It therefore rises one clock after any flag and falls one clock after the last flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base pulse, one clock wide |
| clear_i | input | 1 | Fault clear pulse |
| lvl_full_i | input | 1 | 1 when the liquid is at or above the high switch |
| lvl_half_i | input | 1 | 1 when the liquid is at or above the half switch |
| temp_hot_i | input | 1 | 1 when the temperature is at or above the setpoint |
| fill_open_i | input | 1 | Fill valve command |
| drain_open_i | input | 1 | Drain valve command |
| heat_on_i | input | 1 | Heater command |
| fault_o | output | 5 | Sticky flags: [0] level pair, [1] fill, [2] drain, [3] cold, [4] hot |
| shutdown_o | output | 1 | Registered OR of all flags |

## Verification
The checker tests the following on every cycle:
- the one-cycle delay between the flags and shutdown;
- that flags hold while no clear is present;
- that an impossible level pair is latched;
- that a timer flag never rises in the cycle after its arming condition was false.

Only the bench scenarios can show the exact tick count at which each watchdog expires, the restart of a count when its condition drops for a single cycle, and the difference between clearing a flag with its cause present and with it gone.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    localparam int NUM_FAULTS = 5;
    localparam int NUM_WATCH  = 4;

    typedef enum int unsigned {
        FLT_LEVEL_PAIR = 0,
        FLT_FILL_TIME  = 1,
        FLT_DRAIN_TIME = 2,
        FLT_COLD_TIME  = 3,
        FLT_HOT_TIME   = 4
    } fault_idx_e;

    typedef struct packed {
        logic full;
        logic half;
        logic hot;
    } tank_sense_t;

    typedef struct packed {
        logic fill;
        logic drain;
        logic heat;
    } tank_cmd_t;

    typedef logic [NUM_FAULTS-1:0] fault_vec_t;
    typedef logic [NUM_WATCH-1:0]  watch_vec_t;

    // Level reading that cannot physically occur: full but not half.
    function automatic logic level_pair_bad(input tank_sense_t s);
        return s.full && !s.half;
    endfunction

    // Arming conditions, bit i drives watchdog i (fault index i+1).
    function automatic watch_vec_t watch_arms(input tank_sense_t s, input tank_cmd_t c);
        watch_vec_t a;
        a[0] = c.fill;
        a[1] = c.drain;
        a[2] = c.heat && !s.hot;
        a[3] = s.hot;
        return a;
    endfunction

endpackage

// File: rtl/tfs_watchdog.sv
module tfs_watchdog #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !arm_i) begin
            cnt_q <= '0;
        end else if (tick_i && cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = arm_i && (cnt_q == TOP);

endmodule

// File: rtl/tfs_fault_latch.sv
module tfs_fault_latch #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic [N-1:0] cause_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 1'b0;
            end else begin
                q <= cause_i[i] || (q && !clear_i);
            end
        end
        assign flag_o[i] = q;
    end

endmodule

// File: rtl/tank_fault_supervisor.sv
module tank_fault_supervisor
    import tfs_pkg::*;
#(
    parameter int unsigned FILL_LIMIT  = 20,
    parameter int unsigned DRAIN_LIMIT = 12,
    parameter int unsigned COLD_LIMIT  = 30,
    parameter int unsigned HOT_LIMIT   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       clear_i,
    input  logic       lvl_full_i,
    input  logic       lvl_half_i,
    input  logic       temp_hot_i,
    input  logic       fill_open_i,
    input  logic       drain_open_i,
    input  logic       heat_on_i,
    output logic [4:0] fault_o,
    output logic       shutdown_o
);
    tank_sense_t sense;
    tank_cmd_t   cmd;
    watch_vec_t  arms;
    watch_vec_t  expired;
    fault_vec_t  cause;
    fault_vec_t  flags;
    logic        shut_q;

    assign sense = '{full: lvl_full_i, half: lvl_half_i, hot: temp_hot_i};
    assign cmd   = '{fill: fill_open_i, drain: drain_open_i, heat: heat_on_i};
    assign arms  = watch_arms(sense, cmd);

    for (genvar i = 0; i < NUM_WATCH; i++) begin : g_wd
        localparam int unsigned LIM = (i == 0) ? FILL_LIMIT  :
                                      (i == 1) ? DRAIN_LIMIT :
                                      (i == 2) ? COLD_LIMIT  : HOT_LIMIT;
        tfs_watchdog #(.LIMIT(LIM)) u_wd (
            .clk       (clk),
            .rst       (rst),
            .arm_i     (arms[i]),
            .tick_i    (tick_i),
            .expired_o (expired[i])
        );
    end

    assign cause[FLT_LEVEL_PAIR] = level_pair_bad(sense);
    assign cause[NUM_FAULTS-1:1] = expired;

    tfs_fault_latch #(.N(NUM_FAULTS)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear_i),
        .cause_i (cause),
        .flag_o  (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shut_q <= 1'b0;
        end else begin
            shut_q <= |flags;
        end
    end

    assign fault_o    = flags;
    assign shutdown_o = shut_q;

endmodule

// File: rtl/tfs_checker.sv
module tfs_checker (
    input logic       clk,
    input logic       rst,
    input logic       clear_i,
    input logic       lvl_full_i,
    input logic       lvl_half_i,
    input logic       fill_open_i,
    input logic       drain_open_i,
    input logic [4:0] fault_o,
    input logic       shutdown_o
);
    // R10
    shutdown_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_o != 5'b0) |=> shutdown_o);

    // R10
    shutdown_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_o == 5'b0) |=> !shutdown_o);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((fault_o & $past(fault_o)) == $past(fault_o)));

    // R2
    level_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_full_i && !lvl_half_i) |=> fault_o[0]);

    // R9
    pair_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_i && !(lvl_full_i && !lvl_half_i)) |=> !fault_o[0]);

    // R7
    fill_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
        !fill_open_i |=> !$rose(fault_o[1]));

    // R7
    drain_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
        !drain_open_i |=> !$rose(fault_o[2]));

endmodule

bind tank_fault_supervisor tfs_checker u_tfs_checker (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (clear_i),
    .lvl_full_i   (lvl_full_i),
    .lvl_half_i   (lvl_half_i),
    .fill_open_i  (fill_open_i),
    .drain_open_i (drain_open_i),
    .fault_o      (fault_o),
    .shutdown_o   (shutdown_o)
);

// File: tb/tank_fault_supervisor_bench.sv
module tank_fault_supervisor_bench;

    localparam int FL = 6;
    localparam int DL = 5;
    localparam int CL = 7;
    localparam int HL = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       clear_i = 1'b0;
    logic       lvl_full_i = 1'b0;
    logic       lvl_half_i = 1'b0;
    logic       temp_hot_i = 1'b0;
    logic       fill_open_i = 1'b0;
    logic       drain_open_i = 1'b0;
    logic       heat_on_i = 1'b0;
    logic [4:0] fault_o;
    logic       shutdown_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tank_fault_supervisor #(
        .FILL_LIMIT(FL), .DRAIN_LIMIT(DL), .COLD_LIMIT(CL), .HOT_LIMIT(HL)
    ) u_tank_fault_supervisor (
        .clk(clk), .rst(rst), .tick_i(tick_i), .clear_i(clear_i),
        .lvl_full_i(lvl_full_i), .lvl_half_i(lvl_half_i), .temp_hot_i(temp_hot_i),
        .fill_open_i(fill_open_i), .drain_open_i(drain_open_i), .heat_on_i(heat_on_i),
        .fault_o(fault_o), .shutdown_o(shutdown_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk) clear_i = 1'b1;
        @(negedge clk) clear_i = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 flags", 32'(fault_o), 0);
        chk("R1 shutdown", 32'(shutdown_o), 0);
    endtask

    task automatic t_pair();
        @(negedge clk) begin lvl_full_i = 1'b1; lvl_half_i = 1'b0; end
        @(negedge clk);
        chk("R2 pair flag", 32'(fault_o), 32'b00001);
        chk("R10 shutdown lags flag", 32'(shutdown_o), 0);
        @(negedge clk);
        chk("R10 shutdown up", 32'(shutdown_o), 1);
        pulse_clear();
        chk("R9 clear with cause present", 32'(fault_o[0]), 1);
        @(negedge clk) lvl_half_i = 1'b1;
        wait_cyc(3);
        chk("R8 sticky after cause gone", 32'(fault_o[0]), 1);
        pulse_clear();
        chk("R9 cleared", 32'(fault_o), 0);
        chk("R10 shutdown lags clear", 32'(shutdown_o), 1);
        @(negedge clk);
        chk("R10 shutdown down", 32'(shutdown_o), 0);
        @(negedge clk) begin lvl_full_i = 1'b0; lvl_half_i = 1'b0; end
    endtask

    task automatic t_fill();
        @(negedge clk) fill_open_i = 1'b1;
        wait_cyc(3 * FL);
        chk("R7 no ticks no count", 32'(fault_o[1]), 0);
        ticks(FL - 1);
        wait_cyc(1);
        chk("R3 below limit", 32'(fault_o[1]), 0);
        ticks(1);
        wait_cyc(1);
        chk("R3 at limit", 32'(fault_o), 32'b00010);
        pulse_clear();
        chk("R9 armed timer stays", 32'(fault_o[1]), 1);
        @(negedge clk) fill_open_i = 1'b0;
        pulse_clear();
        chk("R9 fill cleared", 32'(fault_o), 0);
        wait_cyc(1);
    endtask

    task automatic t_drain_restart();
        @(negedge clk) drain_open_i = 1'b1;
        ticks(DL - 1);
        @(negedge clk) drain_open_i = 1'b0;
        @(negedge clk) drain_open_i = 1'b1;
        ticks(DL - 1);
        wait_cyc(1);
        chk("R7 restart after drop", 32'(fault_o[2]), 0);
        ticks(1);
        wait_cyc(1);
        chk("R4 drain limit", 32'(fault_o), 32'b00100);
        @(negedge clk) drain_open_i = 1'b0;
        pulse_clear();
        chk("R4 drain cleared", 32'(fault_o), 0);
    endtask

    task automatic t_cold();
        @(negedge clk) begin heat_on_i = 1'b0; temp_hot_i = 1'b0; end
        ticks(CL + 2);
        wait_cyc(1);
        chk("R5 heater off not armed", 32'(fault_o), 0);
        @(negedge clk) heat_on_i = 1'b1;
        ticks(CL - 1);
        wait_cyc(1);
        chk("R5 cold below limit", 32'(fault_o[3]), 0);
        ticks(1);
        wait_cyc(1);
        chk("R5 cold limit", 32'(fault_o), 32'b01000);
        @(negedge clk) heat_on_i = 1'b0;
        pulse_clear();
        chk("R5 cold cleared", 32'(fault_o), 0);
    endtask

    task automatic t_hot();
        @(negedge clk) begin temp_hot_i = 1'b1; heat_on_i = 1'b1; end
        ticks(HL - 1);
        wait_cyc(1);
        chk("R6 hot below limit", 32'(fault_o[4]), 0);
        ticks(1);
        wait_cyc(1);
        chk("R6 hot limit, cold idle", 32'(fault_o), 32'b10000);
        @(negedge clk) begin temp_hot_i = 1'b0; heat_on_i = 1'b0; end
        wait_cyc(2);
        chk("R8 hot sticky", 32'(fault_o), 32'b10000);
        pulse_clear();
        chk("R9 hot cleared", 32'(fault_o), 0);
        wait_cyc(1);
        chk("R10 all clear", 32'(shutdown_o), 0);
    endtask

    initial begin
        wait_cyc(3);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_pair();
        t_fill();
        t_drain_restart();
        t_cold();
        t_hot();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule